// File: doc/BRIEF.md
# Secure World Memory Access Checker

This block sits on the request path of a processor core and decides, for every memory access, whether the access may proceed. The address space is split into two parts. One is a single secure window, bounded by a base register and a limit register. The other is everything outside that window, which is treated as nonsecure. The checker combines the requested address, the access kind (data read, data write or instruction fetch) and the core's current security state. From these it produces a grant or a fault in the same cycle, and a fault comes with a 2-bit cause code.

The window bounds sit in configuration registers. Only a core running in the secure state may change them; a nonsecure core can still read them through the output ports. The first fault after a clear is recorded in a sticky log that holds the faulting address and its cause. Only a secure-state write to the clear register empties that log. A static enable input turns the whole scheme off, and with it off the block grants everything, as a core without the feature would.

Top module: `secure_access_checker`

## Requirements
- R1: With checking enabled, a nonsecure-state read, write or fetch whose address lies inside the secure window is denied: `acc_grant`=0, `fault`=1, `fault_cause`=2'b01, in the same cycle as `req_valid`.
- R2: With checking enabled, a nonsecure-state read, write or fetch outside the secure window is granted with `fault`=0.
- R3: A secure-state read or write is granted anywhere, and a secure-state fetch inside the window is granted.
- R4: With checking enabled, a secure-state fetch (`req_kind`=2'b10) outside the window is denied with `fault_cause`=2'b10.
- R5: An address is inside the window when base <= address < limit, so the base is included and the limit is excluded. When limit <= base, no address is inside.
- R6: A configuration write (`cfg_wr`) from the secure state, or from any state with checking disabled, updates the selected register one cycle later. `cfg_sel`=0 selects base, 1 selects limit and 2 selects the log clear. The two low bits of base and limit are stored as zero.
- R7: With checking enabled, a nonsecure-state configuration write raises `fault` with `fault_cause`=2'b11 in the same cycle and leaves base, limit and the log unchanged.
- R8: With `sec_enable`=0, every access is granted, every configuration write is accepted and `fault` stays 0.
- R9: The first fault after reset or a clear is captured in the log. An access fault stores the request address, and a register-write fault stores `CFG_ADDR + 4*cfg_sel`. The cause is stored too, and `flog_valid` is set. Later faults do not overwrite the log.
- R10: Only an accepted write with `cfg_sel`=2 empties the log. A nonsecure clear attempt is itself a cause 2'b11 fault and leaves the log as it was.
- R11: After a synchronous reset, base = limit = 0 (empty window), `flog_valid`=0, and with no request `fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_enable | input | 1 | Static enable for world separation |
| req_valid | input | 1 | An access request is present |
| req_addr | input | AW | Word-aligned request address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 treated as data |
| req_secure | input | 1 | Core is in the secure state for this access |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | 0 base, 1 limit, 2 log clear |
| cfg_wdata | input | AW | Write data for base or limit |
| cfg_secure | input | 1 | Core is in the secure state for this write |
| acc_grant | output | 1 | Access allowed |
| fault | output | 1 | Access or register write denied |
| fault_cause | output | 2 | 01 nonsecure to window, 10 secure fetch outside, 11 register write |
| win_base | output | AW | Current window base |
| win_limit | output | AW | Current window limit |
| flog_valid | output | 1 | Log holds a fault |
| flog_addr | output | AW | Logged fault address |
| flog_cause | output | 2 | Logged fault cause |

## Verification
If a bound register held a wrong value, it would show directly on `win_base` or `win_limit` in the cycle after the write. Later it would also appear as a wrong grant at an address next to the edge of the window. The bench therefore probes the addresses exactly at base, at limit and one word below each. A log that was overwritten or cleared when it should not have been shows on `flog_addr`, `flog_cause` or `flog_valid` one cycle after the faulting stimulus, so the log is read back after every fault-related step. Permission errors show up in the same cycle on `acc_grant` and `fault_cause`, and the scoreboard compares these for every request.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_NS_WIN   = 2'b01,
    CAUSE_SEC_FTCH = 2'b10,
    CAUSE_CFG_WR   = 2'b11
  } fault_cause_e;

  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_LIMIT = 2'd1;
  localparam logic [1:0] SEL_CLEAR = 2'd2;
endpackage

// File: rtl/sac_window_match.sv
module sac_window_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic          hit
);
  logic ge_base;
  logic lt_limit;

  always_comb begin
    ge_base  = (addr >= base);
    lt_limit = (addr < limit);
    hit      = ge_base && lt_limit;
  end
endmodule

// File: rtl/sac_perm_matrix.sv
module sac_perm_matrix
  import sac_pkg::*;
(
  input  logic       valid,
  input  logic       enable,
  input  logic       secure,
  input  logic       in_window,
  input  logic [1:0] kind,
  output logic       grant,
  output logic       deny,
  output logic [1:0] cause
);
  logic is_fetch;

  always_comb begin
    is_fetch = (kind == KIND_FETCH);
    grant    = 1'b0;
    deny     = 1'b0;
    cause    = CAUSE_NONE;
    if (valid) begin
      if (!enable) begin
        grant = 1'b1;
      end else if (!secure && in_window) begin
        deny  = 1'b1;
        cause = CAUSE_NS_WIN;
      end else if (secure && is_fetch && !in_window) begin
        deny  = 1'b1;
        cause = CAUSE_SEC_FTCH;
      end else begin
        grant = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sac_cfg_regs.sv
module sac_cfg_regs
  import sac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  input  logic          wr_secure,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] limit_q,
  output logic          wr_deny,
  output logic          clear_req
);
  localparam logic [AW-1:0] ALIGN_MASK = ~{{(AW-2){1'b0}}, 2'b11};

  logic          wr_ok;
  logic [AW-1:0] wdata_al;

  always_comb begin
    wr_deny   = wr && enable && !wr_secure;
    wr_ok     = wr && !wr_deny;
    wdata_al  = wdata & ALIGN_MASK;
    clear_req = wr_ok && (sel == SEL_CLEAR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (wr_ok) begin
      if (sel == SEL_BASE)  base_q  <= wdata_al;
      if (sel == SEL_LIMIT) limit_q <= wdata_al;
    end
  end

  // R7
  blocked_write_keeps_bounds_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && enable && !wr_secure) |=> ($stable(base_q) && $stable(limit_q)));

  // R6
  bounds_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (base_q[1:0] == 2'b00) && (limit_q[1:0] == 2'b00));
endmodule

// File: rtl/sac_fault_log.sv
module sac_fault_log #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_deny,
  input  logic [1:0]    acc_cause,
  input  logic [AW-1:0] acc_addr,
  input  logic          cfg_deny,
  input  logic [AW-1:0] cfg_addr,
  input  logic          clear,
  output logic          vld_q,
  output logic [AW-1:0] addr_q,
  output logic [1:0]    cause_q
);
  logic open_slot;

  always_comb open_slot = !vld_q || clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      addr_q  <= '0;
      cause_q <= 2'b00;
    end else if (open_slot) begin
      if (acc_deny) begin
        vld_q   <= 1'b1;
        addr_q  <= acc_addr;
        cause_q <= acc_cause;
      end else if (cfg_deny) begin
        vld_q   <= 1'b1;
        addr_q  <= cfg_addr;
        cause_q <= 2'b11;
      end else if (clear) begin
        vld_q   <= 1'b0;
      end
    end
  end

  // R9
  log_is_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !clear) |=> (vld_q && $stable(addr_q) && $stable(cause_q)));

  // R10
  log_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (clear && !acc_deny && !cfg_deny) |=> !vld_q);
endmodule

// File: rtl/secure_access_checker.sv
module secure_access_checker
  import sac_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [31:0] CFG_ADDR = 32'hFFFF_F000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sec_enable,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_kind,
  input  logic          req_secure,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          cfg_secure,
  output logic          acc_grant,
  output logic          fault,
  output logic [1:0]    fault_cause,
  output logic [AW-1:0] win_base,
  output logic [AW-1:0] win_limit,
  output logic          flog_valid,
  output logic [AW-1:0] flog_addr,
  output logic [1:0]    flog_cause
);
  localparam logic [AW-1:0] CFG_ADDR_W = CFG_ADDR[AW-1:0];

  logic          in_window;
  logic          acc_deny;
  logic [1:0]    acc_cause;
  logic          cfg_deny;
  logic          clear_req;
  logic [AW-1:0] cfg_fault_addr;

  sac_cfg_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .enable    (sec_enable),
    .wr        (cfg_wr),
    .sel       (cfg_sel),
    .wdata     (cfg_wdata),
    .wr_secure (cfg_secure),
    .base_q    (win_base),
    .limit_q   (win_limit),
    .wr_deny   (cfg_deny),
    .clear_req (clear_req)
  );

  sac_window_match #(.AW(AW)) u_match (
    .addr  (req_addr),
    .base  (win_base),
    .limit (win_limit),
    .hit   (in_window)
  );

  sac_perm_matrix u_perm (
    .valid     (req_valid),
    .enable    (sec_enable),
    .secure    (req_secure),
    .in_window (in_window),
    .kind      (req_kind),
    .grant     (acc_grant),
    .deny      (acc_deny),
    .cause     (acc_cause)
  );

  always_comb begin
    cfg_fault_addr = CFG_ADDR_W + {{(AW-4){1'b0}}, cfg_sel, 2'b00};
    fault          = acc_deny || cfg_deny;
    fault_cause    = acc_deny ? acc_cause : (cfg_deny ? CAUSE_CFG_WR : CAUSE_NONE);
  end

  sac_fault_log #(.AW(AW)) u_log (
    .clk       (clk),
    .rst       (rst),
    .acc_deny  (acc_deny),
    .acc_cause (acc_cause),
    .acc_addr  (req_addr),
    .cfg_deny  (cfg_deny),
    .cfg_addr  (cfg_fault_addr),
    .clear     (clear_req),
    .vld_q     (flog_valid),
    .addr_q    (flog_addr),
    .cause_q   (flog_cause)
  );

  // R1
  ns_into_window_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sec_enable && !req_secure && in_window) |-> (fault && !acc_grant && fault_cause == 2'b01));

  // R4
  sec_fetch_outside_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sec_enable && req_secure && req_kind == 2'b10 && !in_window) |-> (fault && fault_cause == 2'b10));

  // R8
  disabled_grants_chk: assert property (@(posedge clk) disable iff (rst)
    !sec_enable |-> (!fault && (acc_grant == req_valid)));

  // R2
  grant_xor_fault_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (acc_grant != acc_deny));
endmodule

// File: tb/secure_access_checker_tb.sv
`timescale 1ns/1ps
module secure_access_checker_tb;
  localparam int          AW   = 32;
  localparam logic [31:0] CFGA = 32'hFFFF_F000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sec_enable = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_kind = 2'b00;
  logic          req_secure = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = 2'b00;
  logic [AW-1:0] cfg_wdata = '0;
  logic          cfg_secure = 1'b0;
  logic          acc_grant, fault, flog_valid;
  logic [1:0]    fault_cause, flog_cause;
  logic [AW-1:0] win_base, win_limit, flog_addr;

  always #4 clk = ~clk;

  secure_access_checker #(.AW(AW), .CFG_ADDR(CFGA)) u_dut (.*);

  typedef struct {
    logic       grant;
    logic       flt;
    logic [1:0] cause;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model of the block state
  logic [AW-1:0] m_base, m_limit, m_laddr;
  logic          m_lvld;
  logic [1:0]    m_lcause;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic model_reset();
    m_base = '0; m_limit = '0; m_lvld = 1'b0; m_laddr = '0; m_lcause = 2'b00;
  endtask

  task automatic log_fault(input logic [AW-1:0] a, input logic [1:0] c, input logic clr);
    if (!m_lvld || clr) begin m_lvld = 1'b1; m_laddr = a; m_lcause = c; end
  endtask

  task automatic idle();
    @(negedge clk); #1;
    req_valid = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic access(input logic [AW-1:0] a, input logic [1:0] k, input logic s, input string r);
    exp_t e;
    logic hit;
    @(negedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_kind = k; req_secure = s; cfg_wr = 1'b0;
    hit = (a >= m_base) && (a < m_limit);
    e.req = r; e.grant = 1'b1; e.flt = 1'b0; e.cause = 2'b00;
    if (sec_enable) begin
      if (!s && hit) begin e.grant = 0; e.flt = 1; e.cause = 2'b01; end
      else if (s && k == 2'b10 && !hit) begin e.grant = 0; e.flt = 1; e.cause = 2'b10; end
    end
    if (e.flt) log_fault(a, e.cause, 1'b0);
    exp_q.push_back(e);
  endtask

  task automatic cfgw(input logic [1:0] sel, input logic [AW-1:0] d, input logic s, input string r);
    exp_t e;
    @(negedge clk); #1;
    req_valid = 1'b0; cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d; cfg_secure = s;
    e.req = r; e.grant = 1'b0; e.flt = 1'b0; e.cause = 2'b00;
    if (sec_enable && !s) begin
      e.flt = 1'b1; e.cause = 2'b11;
      log_fault(CFGA + {28'd0, sel, 2'b00}, 2'b11, 1'b0);
    end else begin
      if (sel == 2'd0) m_base  = d & ~32'd3;
      if (sel == 2'd1) m_limit = d & ~32'd3;
      if (sel == 2'd2) m_lvld  = 1'b0;
    end
    exp_q.push_back(e);
  endtask

  task automatic check_state(input string r);
    idle();
    @(negedge clk); #3;
    checks++;
    if (win_base !== m_base || win_limit !== m_limit || flog_valid !== m_lvld ||
        (m_lvld && (flog_addr !== m_laddr || flog_cause !== m_lcause))) begin
      errors++;
      $display("FAIL %s state: base=%h limit=%h lvld=%b laddr=%h lcause=%b expected base=%h limit=%h lvld=%b laddr=%h lcause=%b",
               r, win_base, win_limit, flog_valid, flog_addr, flog_cause,
               m_base, m_limit, m_lvld, m_laddr, m_lcause);
    end
  endtask

  task automatic do_reset(input logic en);
    @(negedge clk); #1;
    rst = 1'b1; sec_enable = en; req_valid = 1'b0; cfg_wr = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst = 1'b0;
    model_reset();
  endtask

  // monitor: compares same-cycle outputs with the queued expectation
  initial begin
    forever begin
      @(negedge clk); #3;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (acc_grant !== e.grant || fault !== e.flt || fault_cause !== e.cause) begin
          errors++;
          $display("FAIL %s: grant=%b fault=%b cause=%b expected grant=%b fault=%b cause=%b",
                   e.req, acc_grant, fault, fault_cause, e.grant, e.flt, e.cause);
        end
      end
    end
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    do_reset(1'b1);
    // R11 reset state
    check_state("R11");
    idle(); #2;
    checks++;
    if (fault !== 1'b0) begin errors++; $display("FAIL R11: fault=%b expected 0", fault); end

    // R5 empty window after reset: nonsecure access anywhere granted
    access(32'h0000_0100, 2'b00, 1'b0, "R5");
    // R6 secure configuration of the window; low bits dropped
    cfgw(2'd0, 32'h0000_1001, 1'b1, "R6");
    cfgw(2'd1, 32'h0000_2003, 1'b1, "R6");
    check_state("R6");

    // R1 nonsecure into window, base inclusive (R5)
    access(32'h0000_1000, 2'b00, 1'b0, "R1");
    access(32'h0000_1FFC, 2'b01, 1'b0, "R1");
    access(32'h0000_1800, 2'b10, 1'b0, "R1");
    // R2 nonsecure outside; limit exclusive and base-4 (R5)
    access(32'h0000_2000, 2'b00, 1'b0, "R5");
    access(32'h0000_0FFC, 2'b01, 1'b0, "R2");
    access(32'h0000_3000, 2'b10, 1'b0, "R2");
    // R9 first fault held
    check_state("R9");

    // R3 secure data anywhere, fetch inside
    access(32'h0000_3000, 2'b00, 1'b1, "R3");
    access(32'h0000_0000, 2'b01, 1'b1, "R3");
    access(32'h0000_1004, 2'b10, 1'b1, "R3");
    access(32'h0000_1FFC, 2'b10, 1'b1, "R3");
    // R4 secure fetch outside, both edges
    access(32'h0000_2000, 2'b10, 1'b1, "R4");
    access(32'h0000_0FFC, 2'b10, 1'b1, "R4");

    // R7 nonsecure register writes blocked
    cfgw(2'd0, 32'h0000_0000, 1'b0, "R7");
    cfgw(2'd1, 32'hFFFF_0000, 1'b0, "R7");
    check_state("R7");

    // R10 nonsecure clear refused, secure clear empties
    cfgw(2'd2, 32'h0, 1'b0, "R10");
    check_state("R10");
    cfgw(2'd2, 32'h0, 1'b1, "R10");
    check_state("R10");
    // R9 next fault after clear is a secure fetch
    access(32'h0000_4000, 2'b10, 1'b1, "R9");
    cfgw(2'd0, 32'h0, 1'b0, "R9");
    check_state("R9");
    // R9 register-write fault captured with its register address
    cfgw(2'd2, 32'h0, 1'b1, "R10");
    cfgw(2'd1, 32'h5, 1'b0, "R9");
    check_state("R9");

    // R5 empty window when limit equals base
    cfgw(2'd1, 32'h0000_1000, 1'b1, "R5");
    access(32'h0000_1000, 2'b00, 1'b0, "R5");
    access(32'h0000_1000, 2'b10, 1'b1, "R5");
    check_state("R5");

    // R8 feature disabled
    do_reset(1'b0);
    cfgw(2'd0, 32'h0000_0000, 1'b0, "R8");
    cfgw(2'd1, 32'h0001_0000, 1'b0, "R8");
    access(32'h0000_0100, 2'b10, 1'b0, "R8");
    access(32'h0002_0000, 2'b10, 1'b1, "R8");
    access(32'h0000_0200, 2'b01, 1'b0, "R8");
    check_state("R8");

    idle();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule